// File: doc/BRIEF.md
# Hierarchical Scan-Out Macrocell Tree

This block gathers the observation path of a grid of random-access scan cells onto one scan-out pin. Each cell offers a data bit and a select flag. The block groups the cells in fours. A 4-to-1 macrocell reduces each group to one data bit and one flag. The same macrocell then reduces those results again at each level above, until a single data bit and a single valid flag leave at the root. Two levels of macrocells together cover one 4x4 block of cells. The number of cells is a power of four, and the tree has log4 of that many levels.

Each level can be built with or without an output register. A per-level bit mask chooses this. With no level registered, the root follows the selected cell combinationally. Each registered level adds exactly one clock of latency, which gives a multi-cycle, pipelined read-out.

Whatever addresses the cells raises at most one select flag at a time. The tree keeps to that rule and does not arbitrate between flags.

Top module: `scan_out_tree`

## Requirements
- R1: `scan_vld` is the OR of all `cell_vld` bits, delayed by the tree latency.
- R2: When exactly one `cell_vld[i]` is set, `scan_dat` equals `cell_dat[i]`, delayed by the tree latency.
- R3: When no `cell_vld` bit is set, `scan_dat` is 0, whatever the values on `cell_dat`.
- R4: The tree latency equals the number of set bits of `REG_MASK` among its lowest `DEPTH` positions. Bit 0 is the level next to the cells, and `DEPTH` = log4(`CELLS`).
- R5: With `REG_MASK` = 0, both outputs follow the inputs in the same cycle, with no clock involved.
- R6: While `rst_n` is low, every registered level is cleared, so a registered root drives `scan_vld` = 0 and `scan_dat` = 0.
- R7: More than one `cell_vld` bit set at the same time is illegal. The check inside each macrocell reports it.
- R8: Cell i enters leaf macrocell i/4 on input i%4, and each cell can be read at the root.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered levels |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_dat | input | CELLS | Data bit of every scan cell |
| cell_vld | input | CELLS | Select flag of every scan cell, at most one set |
| scan_dat | output | 1 | Root data bit |
| scan_vld | output | 1 | Root valid flag |

## Verification
The bench builds two trees of 64 cells. The first registers levels 0 and 2, so every result is due two rising edges after the stimulus that caused it. The second has no registered level, so its results are due in the same cycle as the stimulus.

Stimulus changes on the falling edge, and the outputs are sampled one time unit later. The combinational tree is compared against the value expected from the new stimulus. The registered tree is compared against the head of a queue of expected results, which starts with two cleared entries at reset release and then advances by one entry per cycle. Because of the queue, a result that arrives one cycle early or late is reported as a mismatch.

// File: rtl/scan_out_pkg.sv
package scan_out_pkg;

    localparam int unsigned FANIN = 4;

    // number of 4-to-1 levels needed to reduce n leaves to one
    function automatic int unsigned tree_depth(input int unsigned n);
        int unsigned d;
        int unsigned w;
        d = 0;
        w = 1;
        while (w < n) begin
            w = w * FANIN;
            d = d + 1;
        end
        return d;
    endfunction

    // leaf count divided by 4 to the power lvl+1
    function automatic int unsigned nodes_at(input int unsigned n, input int unsigned lvl);
        int unsigned w;
        w = n;
        for (int unsigned k = 0; k <= lvl; k++) w = w / FANIN;
        return w;
    endfunction

endpackage

// File: rtl/so_node.sv
module so_node #(
    parameter bit REG_OUT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] dat_i,
    input  logic [3:0] vld_i,
    output logic       dat_o,
    output logic       vld_o
);
    logic dat_sel;
    logic vld_any;

    always_comb begin
        vld_any = |vld_i;
        dat_sel = |(dat_i & vld_i);
    end

    generate
        if (REG_OUT) begin : g_reg
            logic dat_q;
            logic vld_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dat_q <= 1'b0;
                    vld_q <= 1'b0;
                end else begin
                    dat_q <= dat_sel;
                    vld_q <= vld_any;
                end
            end
            assign dat_o = dat_q;
            assign vld_o = vld_q;

            // R1
            vld_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|vld_i) |=> vld_o);
            // R1
            vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (vld_i == 4'b0) |=> !vld_o);
            // R2
            dat_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot(vld_i) |=> (dat_o == $past(|(dat_i & vld_i))));
            // R6
            rst_clr_chk: assert property (@(posedge clk)
                !rst_n |=> (!vld_o && !dat_o));
        end else begin : g_comb
            assign dat_o = dat_sel;
            assign vld_o = vld_any;
        end
    endgenerate

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> !dat_o);
    // R7
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld_i));

endmodule

// File: rtl/so_stage.sv
module so_stage #(
    parameter int unsigned NODES   = 4,
    parameter bit          REG_OUT = 1'b0,
    localparam int unsigned NIN    = NODES * 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIN-1:0]   dat_i,
    input  logic [NIN-1:0]   vld_i,
    output logic [NODES-1:0] dat_o,
    output logic [NODES-1:0] vld_o
);
    generate
        for (genvar n = 0; n < NODES; n++) begin : g_node
            // R8: inputs 4n..4n+3 feed node n
            so_node #(.REG_OUT(REG_OUT)) u_node (
                .clk  (clk),
                .rst_n(rst_n),
                .dat_i(dat_i[4*n +: 4]),
                .vld_i(vld_i[4*n +: 4]),
                .dat_o(dat_o[n]),
                .vld_o(vld_o[n])
            );
        end
    endgenerate
endmodule

// File: rtl/scan_out_tree.sv
module scan_out_tree
    import scan_out_pkg::*;
#(
    parameter int unsigned CELLS    = 64,
    parameter bit [15:0]   REG_MASK = 16'h0005,
    localparam int unsigned DEPTH   = tree_depth(CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CELLS-1:0] cell_dat,
    input  logic [CELLS-1:0] cell_vld,
    output logic             scan_dat,
    output logic             scan_vld
);
    generate
        for (genvar lv = 0; lv < DEPTH; lv++) begin : g_lvl
            localparam int unsigned NOUT = nodes_at(CELLS, lv);
            localparam int unsigned NIN  = NOUT * FANIN;
            logic [NIN-1:0]  din;
            logic [NIN-1:0]  vin;
            logic [NOUT-1:0] dout;
            logic [NOUT-1:0] vout;
            if (lv == 0) begin : g_src
                assign din = cell_dat;
                assign vin = cell_vld;
            end else begin : g_src
                assign din = g_lvl[lv-1].dout;
                assign vin = g_lvl[lv-1].vout;
            end
            so_stage #(.NODES(NOUT), .REG_OUT(REG_MASK[lv])) u_stage (
                .clk  (clk),
                .rst_n(rst_n),
                .dat_i(din),
                .vld_i(vin),
                .dat_o(dout),
                .vld_o(vout)
            );
        end
    endgenerate

    assign scan_dat = g_lvl[DEPTH-1].dout[0];
    assign scan_vld = g_lvl[DEPTH-1].vout[0];

endmodule

// File: tb/scan_out_tree_test.sv
module scan_out_tree_test;
    localparam int unsigned PERIOD = 10;
    localparam int unsigned N      = 64;
    localparam int unsigned LAT    = 2;   // REG_MASK 'b101 -> two registered levels

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cdat = '0;
    logic [N-1:0] cvld = '0;
    logic         p_dat, p_vld, c_dat, c_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_q[$];      // pairs pushed as {vld, dat}
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    scan_out_tree #(.CELLS(N), .REG_MASK(16'h0005)) uut (
        .clk(clk), .rst_n(rst_n), .cell_dat(cdat), .cell_vld(cvld),
        .scan_dat(p_dat), .scan_vld(p_vld));

    scan_out_tree #(.CELLS(N), .REG_MASK(16'h0000)) uut_c (
        .clk(clk), .rst_n(rst_n), .cell_dat(cdat), .cell_vld(cvld),
        .scan_dat(c_dat), .scan_vld(c_vld));

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // one cycle: drive at falling edge, compare both trees one unit later
    task automatic step(input logic [N-1:0] v, input logic [N-1:0] d);
        bit ev, ed, qv, qd;
        @(negedge clk);
        cvld = v;
        cdat = d;
        ev = |v;
        ed = |(v & d);
        exp_q.push_back(ev);
        exp_q.push_back(ed);
        #1;
        chk(c_vld == ev, "R5 R1 comb valid", c_vld, ev);
        chk(c_dat == ed, (ev ? "R5 R2 comb data" : "R3 comb idle data"), c_dat, ed);
        qv = exp_q.pop_front();
        qd = exp_q.pop_front();
        chk(p_vld == qv, "R4 R1 piped valid", p_vld, qv);
        chk(p_dat == qd, (qv ? "R4 R2 piped data" : "R3 piped idle data"), p_dat, qd);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        // R6: reset holds registered root at zero although a cell is selected
        cvld[5] = 1'b1;
        cdat[5] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        chk(p_vld == 1'b0, "R6 reset valid", p_vld, 0);
        chk(p_dat == 1'b0, "R6 reset data", p_dat, 0);
        chk(c_vld == 1'b1, "R5 comb in reset", c_vld, 1);
        cvld = '0;
        cdat = '0;
        rst_n = 1'b1;
        for (int k = 0; k < int'(LAT); k++) begin
            exp_q.push_back(1'b0);
            exp_q.push_back(1'b0);
        end
        // R8: walk every cell, data one then zero
        for (int i = 0; i < int'(N); i++) begin
            v = '0;
            v[i] = 1'b1;
            step(v, ~('0));
            step(v, ~v);
        end
        // R3: no selection, busy data
        step('0, ~('0));
        step('0, {N/2{2'b10}});
        // R4: isolated pulse followed by idle cycles
        v = '0;
        v[37] = 1'b1;
        step(v, v);
        for (int k = 0; k < 4; k++) step('0, '0);
        // R2: random data with a single random selection, R7 kept legal
        for (int k = 0; k < 200; k++) begin
            logic [N-1:0] d;
            d = {$urandom(), $urandom()};
            v = '0;
            if ($urandom_range(0, 3) != 0) v[$urandom_range(0, N-1)] = 1'b1;
            chk($countones(v) <= 1, "R7 stimulus one-hot", $countones(v), 1);
            step(v, d);
        end
        for (int k = 0; k < 3; k++) step('0, '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule